// File: doc/BRIEF.md
# Cascaded Two-Master Interrupt Aggregator

This block collects 112 interrupt inputs into a single interrupt line for a host processor. The inputs form two masters of seven blocks, and each block holds eight inputs. Every block has its own registers at fixed addresses, so the host never has to select a block first. An input that rises while it is unmasked sets a pending bit. The pending bit stays set until the host writes a 1 to that bit in the block's clear register.

The host first reads the summary register of the first master. Bits 7:1 of a summary register show which blocks of that master have pending inputs. Bit 0 of the first master's summary register shows that the second master has something pending, which saves the host a read when the second master is idle. The host then reads the status register of each flagged block, handles each set bit and writes the bit back to the clear register. A register port with a 10-bit address and 8-bit data gives access to everything. A real-time register per block shows the present input levels.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset every pending bit is 0, every mask register reads 0xFF (all masked), and irq_out is 0.
- R2: On an unmasked input, a 0-to-1 change latches its pending bit at the next rising clock edge. The bit is readable at status address base + b, bit position = input bit. An input held at 1 does not latch again after its bit has been cleared.
- R3: A rising input whose mask bit is 1 leaves its pending bit at 0. Mask registers are read/write at base + b + 8, and 1 means masked.
- R4: Writing to the clear register at base + b + 1 removes the pending bits written as 1. Bits written as 0 leave their pending bits unchanged.
- R5: When a clear and a new rising input hit the same bit in the same cycle, the clear wins and the bit stays 0.
- R6: In a master summary register (address base + 0), bit b (1..7) is 1 exactly when block b of that master has any pending bit.
- R7: Bit 0 of the summary register for master 0 is 1 whenever the summary register for master 1 is nonzero. Bit 0 of the summary register for master 1 always reads 0.
- R8: The real-time register at base + b + 15 reads the present levels of the block's eight inputs.
- R9: irq_out is 1 exactly while at least one summary register is nonzero.
- R10: Reads of any address not listed above return 0. This includes base + 8 and addresses outside both masters.
- R11: The master bases are 0x130 and 0x1B0. Input index = (master*7 + b - 1)*8 + bit for blocks b = 1..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 112 | Interrupt input levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
Read data and irq_out follow the address and the pending state through logic only, with no register in the path. A write, or a change on an input, alters the pending and mask state at the next rising edge. The bench drives all stimulus on the falling edge. Each expected item is stamped with the cycle in which it falls due, which is one rising edge after the stimulus. The monitor compares the item 1 ns after that edge, and the address is not changed again until the next falling edge.

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg #(
  parameter int NMAST    = 2,
  parameter int NBLK     = 7,
  parameter int NBIT     = 8,
  parameter int AW       = 10,
  parameter int M_BASE   = 'h130,
  parameter int M_STRIDE = 'h80,
  parameter int OFF_CLR  = 1,
  parameter int OFF_MASK = 8,
  parameter int OFF_RT   = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NMAST*NBLK*NBIT-1:0] irq_in,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [NBIT-1:0]            wdata,
  output logic [NBIT-1:0]            rdata,
  output logic                       irq_out
);
  localparam int NIRQ = NMAST*NBLK*NBIT;

  logic [NIRQ-1:0] pend_q, mask_q, prev_q, clr_vec, mask_d, rise;
  logic [NBIT-1:0] mreg [NMAST];

  function automatic logic hit(input logic [AW-1:0] a, input int m, input int off);
    return a == AW'(M_BASE + m*M_STRIDE + off);
  endfunction

  always_comb begin
    clr_vec = '0;
    mask_d  = mask_q;
    for (int m = 0; m < NMAST; m++)
      for (int b = 1; b <= NBLK; b++) begin
        if (wr_en && hit(addr, m, b + OFF_CLR))
          clr_vec[(m*NBLK+b-1)*NBIT +: NBIT] = wdata;
        if (wr_en && hit(addr, m, b + OFF_MASK))
          mask_d[(m*NBLK+b-1)*NBIT +: NBIT] = wdata;
      end
  end

  assign rise = irq_in & ~prev_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      prev_q <= '0;
    end else begin
      prev_q <= irq_in;
      mask_q <= mask_d;
      pend_q <= (pend_q | rise) & ~clr_vec;
    end
  end

  always_comb begin
    for (int m = 0; m < NMAST; m++) begin
      mreg[m] = '0;
      for (int b = 1; b <= NBLK; b++)
        mreg[m][b] = |pend_q[(m*NBLK+b-1)*NBIT +: NBIT];
    end
    for (int m = 1; m < NMAST; m++)
      mreg[0][0] = mreg[0][0] | (|mreg[m]);
  end

  assign irq_out = |mreg[0];

  always_comb begin
    rdata = '0;
    for (int m = 0; m < NMAST; m++) begin
      if (hit(addr, m, 0)) rdata = rdata | mreg[m];
      for (int b = 1; b <= NBLK; b++) begin
        if (hit(addr, m, b))
          rdata = rdata | pend_q[(m*NBLK+b-1)*NBIT +: NBIT];
        if (hit(addr, m, b + OFF_MASK))
          rdata = rdata | mask_q[(m*NBLK+b-1)*NBIT +: NBIT];
        if (hit(addr, m, b + OFF_RT))
          rdata = rdata | irq_in[(m*NBLK+b-1)*NBIT +: NBIT];
      end
    end
  end
endmodule

module irq_cascade_agg_chk #(
  parameter int NIRQ = 112
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIRQ-1:0] irq_in,
  input logic            irq_out,
  input logic [NIRQ-1:0] pend_q,
  input logic [NIRQ-1:0] mask_q,
  input logic [NIRQ-1:0] prev_q,
  input logic [NIRQ-1:0] clr_vec
);
  // R2
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(irq_in & ~prev_q)) == '0);

  // R3
  masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & $past(mask_q)) == '0);

  // R4 R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(clr_vec)) == '0);

  // R9
  irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pend_q != '0));
endmodule

bind irq_cascade_agg irq_cascade_agg_chk #(.NIRQ(NMAST*NBLK*NBIT)) u_chk (.*);

// File: tb/irq_cascade_agg_tb.sv
`timescale 1ns/1ps
module irq_cascade_agg_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [111:0] irq_in = '0;
  logic         wr_en = 0;
  logic [9:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         irq_out;

  irq_cascade_agg u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
                         .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  typedef struct {
    int         kind;
    int         due;
    logic [9:0] a;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0, total = 0, fails = 0;
  bit done = 0;

  function automatic int idx(int m, int b, int bt); return (m*7 + b - 1)*8 + bt; endfunction
  function automatic logic [9:0] base(int m); return 10'(32'h130 + m*32'h80); endfunction
  function automatic logic [9:0] stat_a(int m, int b); return base(m) + 10'(b); endfunction
  function automatic logic [9:0] clr_a(int m, int b);  return base(m) + 10'(b + 1); endfunction
  function automatic logic [9:0] mask_a(int m, int b); return base(m) + 10'(b + 8); endfunction
  function automatic logic [9:0] rt_a(int m, int b);   return base(m) + 10'(b + 15); endfunction

  task automatic rd(input logic [9:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.kind = 0; it.due = cyc + 1; it.a = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 1; it.due = cyc + 1; it.a = '0; it.exp = {7'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_in(input int i, input logic v);
    @(negedge clk);
    irq_in[i] = v;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? rdata : {7'd0, irq_out};
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(mask_a(0, 1), 8'hFF, "R1");
    rd(mask_a(1, 7), 8'hFF, "R1");
    rd(stat_a(0, 3), 8'h00, "R1");
    chk_irq(1'b0, "R1");
    // R3 masked input does not latch
    set_in(idx(0, 2, 5), 1);
    rd(stat_a(0, 2), 8'h00, "R3");
    chk_irq(1'b0, "R3");
    set_in(idx(0, 2, 5), 0);
    // unmask
    wr(mask_a(0, 2), 8'h00);
    wr(mask_a(1, 4), 8'h00);
    wr(mask_a(0, 7), 8'h00);
    rd(mask_a(0, 2), 8'h00, "R3");
    // R2 latch, R6 summary, R9 output
    set_in(idx(0, 2, 5), 1);
    rd(stat_a(0, 2), 8'h20, "R2");
    rd(base(0), 8'h04, "R6");
    rd(base(1), 8'h00, "R7");
    chk_irq(1'b1, "R9");
    // R8 live levels
    rd(rt_a(0, 2), 8'h20, "R8");
    set_in(idx(0, 2, 5), 0);
    rd(rt_a(0, 2), 8'h00, "R8");
    rd(stat_a(0, 2), 8'h20, "R2");
    // R4 zero write no effect, one write clears
    wr(clr_a(0, 2), 8'h00);
    rd(stat_a(0, 2), 8'h20, "R4");
    wr(clr_a(0, 2), 8'h20);
    rd(stat_a(0, 2), 8'h00, "R4");
    rd(base(0), 8'h00, "R6");
    chk_irq(1'b0, "R9");
    // R2 held level does not relatch
    set_in(idx(0, 2, 5), 1);
    wr(clr_a(0, 2), 8'h20);
    repeat (2) @(negedge clk);
    rd(stat_a(0, 2), 8'h00, "R2");
    set_in(idx(0, 2, 5), 0);
    // R7 cascade and R11 mapping
    set_in(idx(1, 4, 3), 1);
    rd(stat_a(1, 4), 8'h08, "R11");
    rd(base(1), 8'h10, "R6");
    rd(base(0), 8'h01, "R7");
    chk_irq(1'b1, "R9");
    // R10 unmapped reads while something is pending
    rd(base(0) + 10'd8, 8'h00, "R10");
    rd(10'h000, 8'h00, "R10");
    rd(10'h3FF, 8'h00, "R10");
    wr(clr_a(1, 4), 8'h08);
    rd(base(0), 8'h00, "R7");
    set_in(idx(1, 4, 3), 0);
    // R5 clear wins over same-cycle rise
    @(negedge clk);
    irq_in[idx(0, 7, 0)] = 1;
    addr = clr_a(0, 7); wdata = 8'h01; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    rd(stat_a(0, 7), 8'h00, "R5");
    chk_irq(1'b0, "R5");
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule